// File: doc/BRIEF.md
# BCD Calendar Time Counter

This block keeps a calendar time of day: seconds, minutes, hours, day of week, day of month, month and a two-digit year. It advances by one second on each accepted pulse of a 1 Hz enable. The counter state is held in plain binary. Each field is shown on its own output byte, as packed BCD or as binary and with the hour in 12-hour or 24-hour form. Two format inputs select these forms at run time.

Every accepted second opens an update-in-progress window of `UIP_CYCLES` clock cycles. When the window closes, the time advances, the field bytes are refreshed and a one-cycle update-done strobe is raised. A 3-bit oscillator-select input must hold the running code 010 for seconds to be accepted. A host freezes the counter by raising the set input and writes field bytes through a byte-wide write port. When set falls, the counter decodes the bytes into its state. A write made while set is low is decoded into the state straight away, so the count goes on from the value written.

Top module: `rtc_time_counter`

## Requirements
- R1: After reset, with the format inputs at BCD and 24-hour, the field bytes read year 00, month 01, day of month 01, day of week 01, hour 00, minute 00 and second 00. Update-in-progress and update-done are low.
- R2: A high `tick_1hz_i` is accepted at a clock edge when `osc_sel_i` is 010, `set_i` is low and no window is open. `uip_o` then goes high for exactly `UIP_CYCLES` cycles. In the cycle `uip_o` falls, the time has advanced by one second, the bytes show the new time and `upd_done_o` is high for that one cycle only. A tick that arrives while the window is open is ignored.
- R3: While `osc_sel_i` is any value other than 010, ticks are ignored. No window opens, no done strobe is raised and the bytes keep their values.
- R4: While `set_i` is high, ticks are ignored and any open window is cut short without advancing the time. The bytes change only through host writes.
- R5: When `bin_mode_i` is 0, every byte is packed BCD, with the tens digit in bits 7:4 and the units digit in bits 3:0. When it is 1, every byte is the plain binary value.
- R6: When `hr24_i` is 0, the hour byte shows 1 to 12 in bits 6:0 (hour 0 is shown as 12). Bit 7 is set for hours 12 to 23. On input, a byte with bit 7 set is read as the PM half of the day.
- R7: Seconds and minutes wrap from 59 to 0 and carry into the next field. Hours wrap from 23 to 0 and carry into the day. Day of week counts 1 to 7 and wraps to 1. Month wraps from 12 to 1 and carries into the year, and the year wraps from 99 to 00.
- R8: Day of month wraps to 1 after the last day of the month. April, June, September and November have 30 days. February has 29 days when the full year, `CENTURY_BASE` plus the two-digit year, is divisible by 4 and either not by 100 or by 400; otherwise it has 28.
- R9: When either format input changes while `set_i` is low, all bytes are rewritten in the new format one clock edge later. While `set_i` is high, a format change leaves the bytes untouched.
- R10: When `set_i` falls, the counter decodes the bytes into its state using the current format inputs. The bytes keep the values written until the next update.
- R11: A write while `set_i` is low stores the byte and then decodes all bytes into the counter state. The next update continues from that value.
- R12: `wr_sel_i` chooses the byte written: 0 second, 1 minute, 2 hour, 3 day of week, 4 day of month, 5 month, 6 year. A write with select 7 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_1hz_i | input | 1 | One-cycle enable, once per second |
| osc_sel_i | input | 3 | Oscillator-select field; 010 lets time run |
| bin_mode_i | input | 1 | 1 selects binary bytes, 0 selects packed BCD |
| hr24_i | input | 1 | 1 selects 24-hour, 0 selects 12-hour with PM flag |
| set_i | input | 1 | Freeze updates for host loading |
| wr_en_i | input | 1 | Field byte write strobe |
| wr_sel_i | input | 3 | Field byte select |
| wr_data_i | input | 8 | Field byte write data |
| sec_o | output | 8 | Seconds byte |
| min_o | output | 8 | Minutes byte |
| hour_o | output | 8 | Hours byte |
| wday_o | output | 8 | Day-of-week byte |
| mday_o | output | 8 | Day-of-month byte |
| mon_o | output | 8 | Month byte |
| year_o | output | 8 | Two-digit year byte |
| uip_o | output | 1 | Update-in-progress level |
| upd_done_o | output | 1 | Update-done strobe |

## Verification
The assertions assume the host does not write a byte in the last cycle of an update window. They also assume the format inputs and `set_i` do not change in the cycle a window closes, because a write or reformat there would race the refresh of the bytes. The bench drives every input at the falling edge. It issues writes and format changes only while no window is open, and it waits out each window before the next stimulus. Host bytes are always written in the format currently selected, so decoding yields a valid calendar date.

// File: rtl/rtc_time_pkg.sv
package rtc_time_pkg;
  localparam int unsigned NUM_FIELDS = 7;
  localparam int unsigned SEL_W = $clog2(NUM_FIELDS + 1);
  localparam int FI_SEC  = 0;
  localparam int FI_MIN  = 1;
  localparam int FI_HOUR = 2;
  localparam int FI_WDAY = 3;
  localparam int FI_MDAY = 4;
  localparam int FI_MON  = 5;
  localparam int FI_YEAR = 6;
  localparam logic [2:0] OSC_RUN = 3'b010;

  typedef struct packed {
    logic [6:0] year;
    logic [3:0] mon;
    logic [4:0] mday;
    logic [2:0] wday;
    logic [4:0] hour;
    logic [5:0] min;
    logic [5:0] sec;
  } cal_t;

  localparam cal_t CAL_RST = '{year: 7'd0, mon: 4'd1, mday: 5'd1, wday: 3'd1,
                               hour: 5'd0, min: 6'd0, sec: 6'd0};

  function automatic logic [7:0] to_bcd(input logic [6:0] v);
    int t, hi, lo;
    t  = int'(v);
    hi = t / 10;
    lo = t % 10;
    return {hi[3:0], lo[3:0]};
  endfunction

  function automatic logic [6:0] from_bcd(input logic [7:0] b);
    int t;
    t = int'(b[7:4]) * 10 + int'(b[3:0]);
    return t[6:0];
  endfunction

  function automatic logic [7:0] enc_byte(input logic [6:0] v, input logic bin);
    return bin ? {1'b0, v} : to_bcd(v);
  endfunction

  function automatic logic [6:0] dec_byte(input logic [7:0] b, input logic bin);
    return bin ? b[6:0] : from_bcd(b);
  endfunction
endpackage

// File: rtl/rtc_cal_inc.sv
module rtc_cal_inc
  import rtc_time_pkg::*;
#(
  parameter int CENTURY_BASE = 2000
) (
  input  cal_t cur_i,
  output cal_t nxt_o
);
  int         full_yr;
  logic       leap;
  logic [4:0] dim;

  always_comb begin
    full_yr = CENTURY_BASE + int'(cur_i.year);
    leap    = (full_yr % 4 == 0) && ((full_yr % 100 != 0) || (full_yr % 400 == 0));
    case (cur_i.mon)
      4'd2:                     dim = leap ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:  dim = 5'd30;
      default:                  dim = 5'd31;
    endcase
  end

  // carries ripple sec -> min -> hour -> day fields -> month -> year
  always_comb begin
    nxt_o = cur_i;
    if (cur_i.sec >= 6'd59) begin
      nxt_o.sec = '0;
      if (cur_i.min >= 6'd59) begin
        nxt_o.min = '0;
        if (cur_i.hour >= 5'd23) begin
          nxt_o.hour = '0;
          nxt_o.wday = (cur_i.wday >= 3'd7) ? 3'd1 : cur_i.wday + 3'd1;
          if (cur_i.mday >= dim) begin
            nxt_o.mday = 5'd1;
            if (cur_i.mon >= 4'd12) begin
              nxt_o.mon  = 4'd1;
              nxt_o.year = (cur_i.year >= 7'd99) ? 7'd0 : cur_i.year + 7'd1;
            end else begin
              nxt_o.mon = cur_i.mon + 4'd1;
            end
          end else begin
            nxt_o.mday = cur_i.mday + 5'd1;
          end
        end else begin
          nxt_o.hour = cur_i.hour + 5'd1;
        end
      end else begin
        nxt_o.min = cur_i.min + 6'd1;
      end
    end else begin
      nxt_o.sec = cur_i.sec + 6'd1;
    end
  end
endmodule

// File: rtl/rtc_fmt_enc.sv
module rtc_fmt_enc
  import rtc_time_pkg::*;
(
  input  cal_t                              cal_i,
  input  logic                              bin_i,
  input  logic                              h24_i,
  output logic [NUM_FIELDS-1:0][7:0]        byte_o
);
  logic [NUM_FIELDS-1:0][6:0] val;
  logic [6:0] h12;
  logic       pm;
  logic [7:0] h12_b;

  assign val[FI_SEC]  = {1'b0, cal_i.sec};
  assign val[FI_MIN]  = {1'b0, cal_i.min};
  assign val[FI_HOUR] = {2'b0, cal_i.hour};
  assign val[FI_WDAY] = {4'b0, cal_i.wday};
  assign val[FI_MDAY] = {2'b0, cal_i.mday};
  assign val[FI_MON]  = {3'b0, cal_i.mon};
  assign val[FI_YEAR] = cal_i.year;

  always_comb begin
    pm = cal_i.hour >= 5'd12;
    if (cal_i.hour == 5'd0)       h12 = 7'd12;
    else if (cal_i.hour > 5'd12)  h12 = {2'b0, cal_i.hour - 5'd12};
    else                          h12 = {2'b0, cal_i.hour};
  end

  assign h12_b = enc_byte(h12, bin_i);

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_fld
    if (f == FI_HOUR) begin : g_hour
      assign byte_o[f] = h24_i ? enc_byte(val[f], bin_i) : {pm, h12_b[6:0]};
    end else begin : g_plain
      assign byte_o[f] = enc_byte(val[f], bin_i);
    end
  end
endmodule

// File: rtl/rtc_fmt_dec.sv
module rtc_fmt_dec
  import rtc_time_pkg::*;
(
  input  logic [NUM_FIELDS-1:0][7:0] byte_i,
  input  logic                       bin_i,
  input  logic                       h24_i,
  output cal_t                       cal_o
);
  logic [NUM_FIELDS-1:0][6:0] dv;
  logic [6:0] hr;

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_fld
    if (f == FI_HOUR) begin : g_hour
      // PM flag is not part of the hour digits
      assign dv[f] = dec_byte({1'b0, byte_i[f][6:0]}, bin_i);
    end else begin : g_plain
      assign dv[f] = dec_byte(byte_i[f], bin_i);
    end
  end

  always_comb begin
    if (h24_i) begin
      hr = dv[FI_HOUR];
    end else begin
      hr = (dv[FI_HOUR] == 7'd12) ? 7'd0 : dv[FI_HOUR];
      if (byte_i[FI_HOUR][7]) hr = hr + 7'd12;
    end
  end

  always_comb begin
    cal_o.sec  = dv[FI_SEC][5:0];
    cal_o.min  = dv[FI_MIN][5:0];
    cal_o.hour = hr[4:0];
    cal_o.wday = dv[FI_WDAY][2:0];
    cal_o.mday = dv[FI_MDAY][4:0];
    cal_o.mon  = dv[FI_MON][3:0];
    cal_o.year = dv[FI_YEAR];
  end
endmodule

// File: rtl/rtc_uip_ctrl.sv
module rtc_uip_ctrl #(
  parameter int unsigned UIP_CYCLES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic run_i,
  input  logic hold_i,
  output logic busy_o,
  output logic fire_o
);
  localparam int unsigned CW = $clog2(UIP_CYCLES + 1);
  logic [CW-1:0] cnt_q;

  assign busy_o = cnt_q != '0;
  assign fire_o = run_i && !hold_i && (cnt_q == CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!run_i) begin
      cnt_q <= '0;
    end else if (cnt_q == '0) begin
      if (tick_i) cnt_q <= CW'(UIP_CYCLES);
    end else if (!hold_i) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end
endmodule

// File: rtl/rtc_time_counter.sv
module rtc_time_counter
  import rtc_time_pkg::*;
#(
  parameter int unsigned UIP_CYCLES   = 8,
  parameter int          CENTURY_BASE = 2000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_1hz_i,
  input  logic [2:0]       osc_sel_i,
  input  logic             bin_mode_i,
  input  logic             hr24_i,
  input  logic             set_i,
  input  logic             wr_en_i,
  input  logic [SEL_W-1:0] wr_sel_i,
  input  logic [7:0]       wr_data_i,
  output logic [7:0]       sec_o,
  output logic [7:0]       min_o,
  output logic [7:0]       hour_o,
  output logic [7:0]       wday_o,
  output logic [7:0]       mday_o,
  output logic [7:0]       mon_o,
  output logic [7:0]       year_o,
  output logic             uip_o,
  output logic             upd_done_o
);
  localparam logic [NUM_FIELDS-1:0][7:0] FLD_RST = 56'h00_01_01_01_00_00_00;

  cal_t cal_q, cal_inc, cal_dec, enc_src;
  logic [NUM_FIELDS-1:0][7:0] fld_q, enc_bytes;
  logic [1:0] fmt_q;
  logic set_q, reload_q, done_q;
  logic run, fire, fmt_chg, upd_bytes;

  assign run       = (osc_sel_i == OSC_RUN) && !set_i;
  assign fmt_chg   = (fmt_q != {bin_mode_i, hr24_i}) && !set_i;
  assign enc_src   = fire ? cal_inc : cal_q;
  assign upd_bytes = fire || fmt_chg;

  rtc_uip_ctrl #(.UIP_CYCLES(UIP_CYCLES)) u_uip (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_1hz_i),
    .run_i  (run),
    .hold_i (reload_q),
    .busy_o (uip_o),
    .fire_o (fire)
  );

  rtc_cal_inc #(.CENTURY_BASE(CENTURY_BASE)) u_inc (
    .cur_i (cal_q),
    .nxt_o (cal_inc)
  );

  rtc_fmt_enc u_enc (
    .cal_i  (enc_src),
    .bin_i  (bin_mode_i),
    .h24_i  (hr24_i),
    .byte_o (enc_bytes)
  );

  rtc_fmt_dec u_dec (
    .byte_i (fld_q),
    .bin_i  (bin_mode_i),
    .h24_i  (hr24_i),
    .cal_o  (cal_dec)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      set_q    <= 1'b0;
      fmt_q    <= 2'b01;
      reload_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      set_q    <= set_i;
      fmt_q    <= {bin_mode_i, hr24_i};
      reload_q <= (wr_en_i && !set_i) || (set_q && !set_i);
      done_q   <= fire;
    end
  end

  // reload has priority; fire is held off while a reload is pending
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cal_q <= CAL_RST;
    end else if (reload_q) begin
      cal_q <= cal_dec;
    end else if (fire) begin
      cal_q <= cal_inc;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fld_q <= FLD_RST;
    end else begin
      if (upd_bytes) fld_q <= enc_bytes;
      for (int f = 0; f < NUM_FIELDS; f++) begin
        if (wr_en_i && (wr_sel_i == SEL_W'(f))) fld_q[f] <= wr_data_i;
      end
    end
  end

  assign sec_o      = fld_q[FI_SEC];
  assign min_o      = fld_q[FI_MIN];
  assign hour_o     = fld_q[FI_HOUR];
  assign wday_o     = fld_q[FI_WDAY];
  assign mday_o     = fld_q[FI_MDAY];
  assign mon_o      = fld_q[FI_MON];
  assign year_o     = fld_q[FI_YEAR];
  assign upd_done_o = done_q;
endmodule

// File: rtl/rtc_time_counter_chk.sv
module rtc_time_counter_chk #(
  parameter int unsigned UIP_CYCLES = 8
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] osc_sel_i,
  input logic       set_i,
  input logic       wr_en_i,
  input logic       uip_o,
  input logic       upd_done_o,
  input logic [7:0] sec_o,
  input logic [7:0] min_o,
  input logic [7:0] hour_o,
  input logic [7:0] wday_o,
  input logic [7:0] mday_o,
  input logic [7:0] mon_o,
  input logic [7:0] year_o
);
  logic [15:0] uip_len_q;
  logic [55:0] bytes;

  assign bytes = {year_o, mon_o, mday_o, wday_o, hour_o, min_o, sec_o};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    uip_len_q <= '0;
    else if (uip_o) uip_len_q <= uip_len_q + 16'd1;
    else            uip_len_q <= '0;
  end

  // R2
  done_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_done_o |-> (!uip_o && uip_len_q == 16'(UIP_CYCLES)));

  // R2
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_done_o |=> !upd_done_o);

  // R3
  osc_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (osc_sel_i != 3'b010) |=> !uip_o);

  // R4
  set_no_uip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> !uip_o);

  // R4
  set_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(set_i) && !$past(wr_en_i)) |-> $stable(bytes));
endmodule

bind rtc_time_counter rtc_time_counter_chk #(.UIP_CYCLES(UIP_CYCLES)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .osc_sel_i  (osc_sel_i),
  .set_i      (set_i),
  .wr_en_i    (wr_en_i),
  .uip_o      (uip_o),
  .upd_done_o (upd_done_o),
  .sec_o      (sec_o),
  .min_o      (min_o),
  .hour_o     (hour_o),
  .wday_o     (wday_o),
  .mday_o     (mday_o),
  .mon_o      (mon_o),
  .year_o     (year_o)
);

// File: tb/tb_rtc_time_counter.sv
module tb_rtc_time_counter;
  localparam int UIP = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [2:0] osc = 3'b010;
  logic       bin = 1'b0;
  logic       h24 = 1'b1;
  logic       set = 1'b0;
  logic       wen = 1'b0;
  logic [2:0] wsel = '0;
  logic [7:0] wdat = '0;
  logic [7:0] sec, mnt, hr, wd, md, mo, yr;
  logic       uip, done;
  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  rtc_time_counter #(.UIP_CYCLES(UIP), .CENTURY_BASE(2000)) dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_1hz_i(tick), .osc_sel_i(osc),
    .bin_mode_i(bin), .hr24_i(h24), .set_i(set), .wr_en_i(wen),
    .wr_sel_i(wsel), .wr_data_i(wdat), .sec_o(sec), .min_o(mnt),
    .hour_o(hr), .wday_o(wd), .mday_o(md), .mon_o(mo), .year_o(yr),
    .uip_o(uip), .upd_done_o(done)
  );

  function automatic logic [55:0] now_bytes();
    return {yr, mo, md, wd, hr, mnt, sec};
  endfunction

  task automatic chk(input string req, input string what, input logic [55:0] act, input logic [55:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk); wen = 1'b1; wsel = s; wdat = d;
    @(negedge clk); wen = 1'b0;
  endtask

  // bytes packed {year,mon,mday,wday,hour,min,sec}
  task automatic load(input logic [55:0] v);
    @(negedge clk); set = 1'b1;
    for (int f = 0; f < 7; f++) wr(3'(f), v[8*f +: 8]);
    set = 1'b0;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic step(input string req, input logic extra);
    logic ok_uip;
    ok_uip = 1'b1;
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    for (int i = 0; i < UIP; i++) begin
      if (i > 0) @(negedge clk);
      if (!uip || done) ok_uip = 1'b0;
      if (extra && i == 2) tick = 1'b1;
      if (extra && i == 3) tick = 1'b0;
    end
    chk("R2", {req, " uip window"}, 56'(ok_uip), 56'd1);
    @(negedge clk);
    chk("R2", {req, " done at window end"}, {54'd0, uip, done}, 56'd1);
    @(negedge clk);
    chk("R2", {req, " done single"}, 56'(done), 56'd0);
  endtask

  task automatic quiet(input string req, input int n);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (uip || done) ok = 1'b0;
    end
    chk(req, "no window or done", 56'(ok), 56'd1);
  endtask

  task automatic t_reset();
    chk("R1", "reset bytes", now_bytes(), 56'h00_01_01_01_00_00_00);
    chk("R1", "reset flags", {54'd0, uip, done}, 56'd0);
  endtask

  task automatic t_rollover();
    load(56'h99_12_31_07_23_59_58);
    chk("R10", "bytes kept after load", now_bytes(), 56'h99_12_31_07_23_59_58);
    step("R7", 1'b0);
    chk("R7", "59 seconds", now_bytes(), 56'h99_12_31_07_23_59_59);
    step("R7", 1'b0);
    chk("R7", "full rollover", now_bytes(), 56'h00_01_01_01_00_00_00);
    step("R2", 1'b1);
    chk("R2", "extra tick ignored", now_bytes(), 56'h00_01_01_01_00_00_01);
  endtask

  task automatic t_osc();
    @(negedge clk); osc = 3'b110;
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    quiet("R3", 12);
    chk("R3", "time held", now_bytes(), 56'h00_01_01_01_00_00_01);
    osc = 3'b010;
  endtask

  task automatic t_set();
    @(negedge clk); set = 1'b1;
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    quiet("R4", 12);
    set = 1'b0;
    @(negedge clk); @(negedge clk);
    tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R4", "window open before abort", 56'(uip), 56'd1);
    set = 1'b1;
    quiet("R4", 12);
    set = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R4", "aborted window no advance", now_bytes(), 56'h00_01_01_01_00_00_01);
    step("R4", 1'b0);
    chk("R4", "resumes after set", now_bytes(), 56'h00_01_01_01_00_00_02);
  endtask

  task automatic t_formats();
    load(56'h24_02_28_03_13_05_09);
    bin = 1'b1;
    @(negedge clk);
    chk("R5", "binary bytes", now_bytes(), 56'h18_02_1C_03_0D_05_09);
    h24 = 1'b0;
    @(negedge clk);
    chk("R6", "binary 12h pm", now_bytes(), 56'h18_02_1C_03_81_05_09);
    bin = 1'b0;
    @(negedge clk);
    chk("R9", "bcd 12h reformat", now_bytes(), 56'h24_02_28_03_81_05_09);
    h24 = 1'b1;
    @(negedge clk);
    chk("R9", "bcd 24h reformat", now_bytes(), 56'h24_02_28_03_13_05_09);
    set = 1'b1;
    @(negedge clk); bin = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R9", "no reformat under set", now_bytes(), 56'h24_02_28_03_13_05_09);
    bin = 1'b0;
    @(negedge clk); set = 1'b0;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic t_leap();
    load(56'h24_02_28_03_23_59_59);
    step("R8", 1'b0);
    chk("R8", "leap year feb 29", now_bytes(), 56'h24_02_29_04_00_00_00);
    load(56'h24_02_29_04_23_59_59);
    step("R8", 1'b0);
    chk("R8", "leap feb end", now_bytes(), 56'h24_03_01_05_00_00_00);
    load(56'h23_02_28_02_23_59_59);
    step("R8", 1'b0);
    chk("R8", "common year feb end", now_bytes(), 56'h23_03_01_03_00_00_00);
    load(56'h00_02_28_01_23_59_59);
    step("R8", 1'b0);
    chk("R8", "year 2000 leap", now_bytes(), 56'h00_02_29_02_00_00_00);
    load(56'h10_04_30_05_23_59_59);
    step("R8", 1'b0);
    chk("R8", "30-day month", now_bytes(), 56'h10_05_01_06_00_00_00);
  endtask

  task automatic t_12h();
    @(negedge clk); h24 = 1'b0;
    @(negedge clk);
    load(56'h24_03_01_05_12_59_59);
    step("R6", 1'b0);
    chk("R6", "12 am to 1 am", now_bytes(), 56'h24_03_01_05_01_00_00);
    load(56'h24_03_01_05_11_59_59);
    step("R6", 1'b0);
    chk("R6", "noon pm flag", now_bytes(), 56'h24_03_01_05_92_00_00);
    load(56'h24_03_01_05_91_59_59);
    step("R6", 1'b0);
    chk("R6", "midnight rollover", now_bytes(), 56'h24_03_02_06_12_00_00);
    h24 = 1'b1;
    @(negedge clk);
    chk("R9", "back to 24h", now_bytes(), 56'h24_03_02_06_00_00_00);
  endtask

  task automatic t_live_write();
    wr(3'd0, 8'h30);
    chk("R12", "sec byte written", now_bytes(), 56'h24_03_02_06_00_00_30);
    @(negedge clk);
    step("R11", 1'b0);
    chk("R11", "continues from written sec", now_bytes(), 56'h24_03_02_06_00_00_31);
    wr(3'd7, 8'h55);
    @(negedge clk);
    chk("R12", "select 7 ignored", now_bytes(), 56'h24_03_02_06_00_00_31);
    wr(3'd1, 8'h45);
    @(negedge clk);
    step("R11", 1'b0);
    chk("R11", "minute reload", now_bytes(), 56'h24_03_02_06_00_45_32);
  endtask

  initial begin
    #4_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rollover();
    t_osc();
    t_set();
    t_formats();
    t_leap();
    t_12h();
    t_live_write();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule